// File: doc/BRIEF.md
# General Purpose Register File with Load Scoreboard

This block holds the general purpose registers of a small 16-bit processor core. It has two read ports that return data in the same cycle and one clocked write port. Next to each register sits a resolved bit that records whether an asynchronous memory load into that register is still outstanding. When the core issues a load, it names the destination register and that register's bit drops. When the memory system later returns the load, the block writes the data and raises the bit again.

While a load is outstanding, any enabled read of its destination asserts a stall output. The pipeline holds until the data arrives. If the data arrives in the same cycle as the read, it is forwarded straight to the read port and no stall is raised. Register zero is a constant zero. A separate link input lets a jump-and-link operation write its return address into register one. The decoder, the ALU and the memory system sit outside the block.

Top module: `gpr_scoreboard`

## Requirements
- R1: The block holds eight 16-bit registers, selected by a 3-bit index. Both read ports return the addressed register in the same cycle. A write on the synchronous port updates its register at the next rising clock edge.
- R2: Index 0 always reads as zero. A write, load issue or load completion that targets index 0 has no effect, and a read of index 0 never stalls.
- R3: When `link_en` is high, `link_addr` is stored into register 1 at the next rising edge.
- R4: When `ld_issue` is high with a nonzero `ld_idx`, the resolved bit of that register is cleared at the next rising edge.
- R5: `stall` is high exactly when an enabled read port addresses a register whose resolved bit is clear and that register is not completing in the same cycle. A read port whose enable is low never causes a stall.
- R6: When `ld_done` is high with a nonzero `ld_done_idx`, `ld_done_data` is written to that register and its resolved bit is set at the same rising edge.
- R7: When a read port addresses the register that is completing in the same cycle, the port returns `ld_done_data` and does not cause a stall.
- R8: After reset, every register reads zero and every resolved bit is set.
- R9: When several writes hit one register in the same cycle, the stored value comes from the load completion first, then the link write, then the synchronous write port.
- R10: When a load issue and a load completion name the same register in the same cycle, the completion data is stored and the resolved bit ends clear.
- R11: A synchronous or link write to a register with an outstanding load updates its data but leaves its resolved bit clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_en | input | 1 | Read port A is in use |
| rd_a_idx | input | 3 | Read port A register index |
| rd_a_data | output | 16 | Read port A data |
| rd_b_en | input | 1 | Read port B is in use |
| rd_b_idx | input | 3 | Read port B register index |
| rd_b_data | output | 16 | Read port B data |
| wr_en | input | 1 | Synchronous write enable |
| wr_idx | input | 3 | Synchronous write register index |
| wr_data | input | 16 | Synchronous write data |
| ld_issue | input | 1 | A load is issued this cycle |
| ld_idx | input | 3 | Destination register of the issued load |
| ld_done | input | 1 | A load completes this cycle |
| ld_done_idx | input | 3 | Destination register of the completing load |
| ld_done_data | input | 16 | Data of the completing load |
| link_en | input | 1 | Store a return address into register 1 |
| link_addr | input | 16 | Return address |
| stall | output | 1 | An enabled read waits on an outstanding load |

## Verification
The assertions check on every cycle the properties that can be stated locally. A read of a register issued on the previous cycle stalls. A completion is stored and reads back on the next cycle. Forwarded data appears in the same cycle. A link write lands in register 1. Register 0 reads zero, and no stall occurs without an enabled read.

Other behaviour depends on history over many cycles, so only the bench's scenarios and its cycle-by-cycle reference model can show it. This covers write priority when several sources collide on one register, issue and completion in the same cycle, writes to a register with an outstanding load, and the reset contents.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam int GPR_COUNT  = 8;
  localparam int GPR_WIDTH  = 16;
  localparam int GPR_LINK   = 1;
  localparam int GPR_RDPORT = 2;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_SYNC = 2'd1,
    SRC_LINK = 2'd2,
    SRC_LOAD = 2'd3
  } wsrc_e;
endpackage

// File: rtl/gpr_bank.sv
module gpr_bank #(
  parameter int NREG     = gpr_pkg::GPR_COUNT,
  parameter int DW       = gpr_pkg::GPR_WIDTH,
  parameter int LINK_IDX = gpr_pkg::GPR_LINK,
  localparam int IW      = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IW-1:0]            wr_idx,
  input  logic [DW-1:0]            wr_data,
  input  logic                     link_en,
  input  logic [DW-1:0]            link_addr,
  input  logic                     done_en,
  input  logic [IW-1:0]            done_idx,
  input  logic [DW-1:0]            done_data,
  output logic [NREG-1:0][DW-1:0]  regs_q
);
  import gpr_pkg::*;

  // index 0 is a constant, never stored
  assign regs_q[0] = '0;

  for (genvar g = 1; g < NREG; g++) begin : g_reg
    wsrc_e         sel;
    logic [DW-1:0] nxt;
    logic [DW-1:0] q;

    always_comb begin
      if (done_en && done_idx == IW'(g))
        sel = SRC_LOAD;
      else if (link_en && g == LINK_IDX)
        sel = SRC_LINK;
      else if (wr_en && wr_idx == IW'(g))
        sel = SRC_SYNC;
      else
        sel = SRC_NONE;
    end

    always_comb begin
      case (sel)
        SRC_LOAD: nxt = done_data;
        SRC_LINK: nxt = link_addr;
        SRC_SYNC: nxt = wr_data;
        default:  nxt = q;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= '0;
      else if (sel != SRC_NONE)
        q <= nxt;
    end

    assign regs_q[g] = q;
  end
endmodule

// File: rtl/gpr_pending.sv
module gpr_pending #(
  parameter int NREG = gpr_pkg::GPR_COUNT,
  localparam int IW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            iss_en,
  input  logic [IW-1:0]   iss_idx,
  input  logic            done_en,
  input  logic [IW-1:0]   done_idx,
  output logic [NREG-1:0] res_q
);
  // register 0 never waits on a load
  assign res_q[0] = 1'b1;

  for (genvar g = 1; g < NREG; g++) begin : g_bit
    logic set_c;
    logic clr_c;
    logic ena_c;
    logic nxt_c;
    logic q;

    always_comb begin
      set_c = done_en && done_idx == IW'(g);
      clr_c = iss_en && iss_idx == IW'(g);
      ena_c = set_c || clr_c;
      // a fresh issue outranks a completion of the older load
      nxt_c = clr_c ? 1'b0 : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= 1'b1;
      else if (ena_c)
        q <= nxt_c;
    end

    assign res_q[g] = q;
  end
endmodule

// File: rtl/gpr_rdport.sv
module gpr_rdport #(
  parameter int NREG = gpr_pkg::GPR_COUNT,
  parameter int DW   = gpr_pkg::GPR_WIDTH,
  localparam int IW  = $clog2(NREG)
) (
  input  logic                    en,
  input  logic [IW-1:0]           idx,
  input  logic [NREG-1:0][DW-1:0] regs_q,
  input  logic [NREG-1:0]         res_q,
  input  logic                    done_en,
  input  logic [IW-1:0]           done_idx,
  input  logic [DW-1:0]           done_data,
  output logic [DW-1:0]           data,
  output logic                    wait_o
);
  logic fwd;

  always_comb begin
    fwd    = done_en && done_idx == idx && idx != '0;
    data   = fwd ? done_data : regs_q[idx];
    wait_o = en && !res_q[idx] && !fwd;
  end
endmodule

// File: rtl/gpr_scoreboard.sv
module gpr_scoreboard #(
  parameter int NREG     = gpr_pkg::GPR_COUNT,
  parameter int DW       = gpr_pkg::GPR_WIDTH,
  parameter int LINK_IDX = gpr_pkg::GPR_LINK,
  localparam int IW      = $clog2(NREG),
  localparam int NRD     = gpr_pkg::GPR_RDPORT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_a_en,
  input  logic [IW-1:0] rd_a_idx,
  output logic [DW-1:0] rd_a_data,
  input  logic          rd_b_en,
  input  logic [IW-1:0] rd_b_idx,
  output logic [DW-1:0] rd_b_data,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          ld_issue,
  input  logic [IW-1:0] ld_idx,
  input  logic          ld_done,
  input  logic [IW-1:0] ld_done_idx,
  input  logic [DW-1:0] ld_done_data,
  input  logic          link_en,
  input  logic [DW-1:0] link_addr,
  output logic          stall
);
  logic [NREG-1:0][DW-1:0] regs_q;
  logic [NREG-1:0]         res_q;
  logic [NRD-1:0]          port_en;
  logic [NRD-1:0][IW-1:0]  port_idx;
  logic [NRD-1:0][DW-1:0]  port_data;
  logic [NRD-1:0]          port_wait;

  assign port_en   = {rd_b_en, rd_a_en};
  assign port_idx  = {rd_b_idx, rd_a_idx};
  assign rd_a_data = port_data[0];
  assign rd_b_data = port_data[1];
  assign stall     = |port_wait;

  gpr_bank #(.NREG(NREG), .DW(DW), .LINK_IDX(LINK_IDX)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .link_en   (link_en),
    .link_addr (link_addr),
    .done_en   (ld_done),
    .done_idx  (ld_done_idx),
    .done_data (ld_done_data),
    .regs_q    (regs_q)
  );

  gpr_pending #(.NREG(NREG)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .iss_en   (ld_issue),
    .iss_idx  (ld_idx),
    .done_en  (ld_done),
    .done_idx (ld_done_idx),
    .res_q    (res_q)
  );

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    gpr_rdport #(.NREG(NREG), .DW(DW)) u_rd (
      .en        (port_en[p]),
      .idx       (port_idx[p]),
      .regs_q    (regs_q),
      .res_q     (res_q),
      .done_en   (ld_done),
      .done_idx  (ld_done_idx),
      .done_data (ld_done_data),
      .data      (port_data[p]),
      .wait_o    (port_wait[p])
    );
  end
endmodule

// File: rtl/gpr_scoreboard_chk.sv
module gpr_scoreboard_chk #(
  parameter int NREG     = 8,
  parameter int DW       = 16,
  parameter int LINK_IDX = 1,
  localparam int IW      = $clog2(NREG)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_a_en,
  input logic [IW-1:0] rd_a_idx,
  input logic [DW-1:0] rd_a_data,
  input logic          rd_b_en,
  input logic          ld_issue,
  input logic [IW-1:0] ld_idx,
  input logic          ld_done,
  input logic [IW-1:0] ld_done_idx,
  input logic [DW-1:0] ld_done_data,
  input logic          link_en,
  input logic [DW-1:0] link_addr,
  input logic          stall
);
  logic past_ok;
  logic a_hit_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      past_ok <= 1'b0;
    else
      past_ok <= 1'b1;
  end

  assign a_hit_done = ld_done && ld_done_idx == rd_a_idx;

  AST_ISSUE_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(ld_issue && ld_idx != '0) && rd_a_en &&
     rd_a_idx == $past(ld_idx) && !a_hit_done) |-> stall); // R4

  AST_DONE_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(ld_done && ld_done_idx != '0) &&
     rd_a_idx == $past(ld_done_idx) && !a_hit_done) |-> rd_a_data == $past(ld_done_data)); // R6

  AST_FWD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_en && a_hit_done && rd_a_idx != '0) |-> rd_a_data == ld_done_data); // R7

  AST_LINK_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(link_en && !(ld_done && ld_done_idx == IW'(LINK_IDX))) &&
     rd_a_idx == IW'(LINK_IDX) && !a_hit_done) |-> rd_a_data == $past(link_addr)); // R3

  AST_ZERO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == '0) |-> rd_a_data == '0); // R2

  AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_a_en && !rd_b_en) |-> !stall); // R5
endmodule

bind gpr_scoreboard gpr_scoreboard_chk #(.NREG(NREG), .DW(DW), .LINK_IDX(LINK_IDX)) u_chk (.*);

// File: tb/sim_gpr_scoreboard.sv
`timescale 1ns/1ps
module sim_gpr_scoreboard;
  logic        clk;
  logic        rst_n;
  logic        rd_a_en, rd_b_en;
  logic [2:0]  rd_a_idx, rd_b_idx;
  logic [15:0] rd_a_data, rd_b_data;
  logic        wr_en;
  logic [2:0]  wr_idx;
  logic [15:0] wr_data;
  logic        ld_issue;
  logic [2:0]  ld_idx;
  logic        ld_done;
  logic [2:0]  ld_done_idx;
  logic [15:0] ld_done_data;
  logic        link_en;
  logic [15:0] link_addr;
  logic        stall;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [15:0] m_val [8];
  bit          m_ok  [8];

  gpr_scoreboard u0 (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected < 20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [15:0] exp_data(logic [2:0] i);
    if (i == 3'd0) return 16'h0;
    if (ld_done && ld_done_idx == i) return ld_done_data;
    return m_val[i];
  endfunction

  function automatic bit exp_wait(logic en, logic [2:0] i);
    if (!en || i == 3'd0) return 1'b0;
    if (ld_done && ld_done_idx == i) return 1'b0;
    return !m_ok[i];
  endfunction

  task automatic idle();
    rd_a_en = 0; rd_a_idx = 0; rd_b_en = 0; rd_b_idx = 0;
    wr_en = 0; wr_idx = 0; wr_data = 0;
    ld_issue = 0; ld_idx = 0; ld_done = 0; ld_done_idx = 0; ld_done_data = 0;
    link_en = 0; link_addr = 0;
  endtask

  task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // compare at mid-cycle, advance the model, then return at the next falling edge
  task automatic cyc(string tag);
    logic [15:0] nv [8];
    bit          nb [8];
    #1;
    check(tag, "rd_a_data", rd_a_data, exp_data(rd_a_idx));
    check(tag, "rd_b_data", rd_b_data, exp_data(rd_b_idx));
    check(tag, "stall", {15'h0, stall},
          {15'h0, exp_wait(rd_a_en, rd_a_idx) | exp_wait(rd_b_en, rd_b_idx)});
    for (int i = 0; i < 8; i++) begin nv[i] = m_val[i]; nb[i] = m_ok[i]; end
    if (wr_en) nv[wr_idx] = wr_data;
    if (link_en) nv[1] = link_addr;
    if (ld_done) begin nv[ld_done_idx] = ld_done_data; nb[ld_done_idx] = 1; end
    if (ld_issue) nb[ld_idx] = 0;
    nv[0] = 0; nb[0] = 1;
    @(posedge clk);
    for (int i = 0; i < 8; i++) begin m_val[i] = nv[i]; m_ok[i] = nb[i]; end
    @(negedge clk);
  endtask

  task automatic rd(logic [2:0] a, logic [2:0] b);
    rd_a_en = 1; rd_a_idx = a; rd_b_en = 1; rd_b_idx = b;
  endtask

  initial begin
    idle();
    for (int i = 0; i < 8; i++) begin m_val[i] = 0; m_ok[i] = 1; end
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R8: reset contents, nothing pending
    for (int i = 0; i < 8; i += 2) begin rd(3'(i), 3'(i + 1)); cyc("R8"); end

    // R1: fill registers through the write port, read back
    for (int i = 1; i < 8; i++) begin
      idle(); wr_en = 1; wr_idx = 3'(i); wr_data = 16'hA000 + 16'(i); cyc("R1");
    end
    idle();
    for (int i = 1; i < 8; i++) begin rd(3'(i), 3'(8 - i)); cyc("R1"); end

    // R2: writes, issue and completion at index 0 are void
    idle(); wr_en = 1; wr_idx = 0; wr_data = 16'hFFFF; ld_issue = 1; ld_idx = 0; cyc("R2");
    idle(); rd(0, 0); ld_done = 1; ld_done_idx = 0; ld_done_data = 16'h1234; cyc("R2");
    idle(); rd(0, 0); cyc("R2");

    // R4, R5: issue to r3, reads stall; disabled port does not
    idle(); ld_issue = 1; ld_idx = 3; cyc("R4");
    idle(); rd(3, 2); cyc("R4");
    idle(); rd_a_idx = 3; rd_b_en = 1; rd_b_idx = 4; cyc("R5");
    idle(); rd(5, 3); cyc("R5");

    // R7 then R6: completion forwarded, then stored
    idle(); rd(3, 3); ld_done = 1; ld_done_idx = 3; ld_done_data = 16'h5A5A; cyc("R7");
    idle(); rd(3, 6); cyc("R6");

    // R3: link write into r1
    idle(); link_en = 1; link_addr = 16'h0C40; cyc("R3");
    idle(); rd(1, 2); cyc("R3");

    // R9: completion beats the write port, then link beats the write port
    idle(); wr_en = 1; wr_idx = 5; wr_data = 16'h1111;
    ld_done = 1; ld_done_idx = 5; ld_done_data = 16'h2222; cyc("R9");
    idle(); rd(5, 1); cyc("R9");
    idle(); wr_en = 1; wr_idx = 1; wr_data = 16'h3333; link_en = 1; link_addr = 16'h4444; cyc("R9");
    idle(); rd(1, 5); cyc("R9");
    idle(); wr_en = 1; wr_idx = 1; wr_data = 16'h5555; link_en = 1; link_addr = 16'h6666;
    ld_done = 1; ld_done_idx = 1; ld_done_data = 16'h7777; cyc("R9");
    idle(); rd(1, 1); cyc("R9");

    // R10: issue and completion on r4 together
    idle(); ld_issue = 1; ld_idx = 4; ld_done = 1; ld_done_idx = 4; ld_done_data = 16'h0BEE; cyc("R10");
    idle(); rd(4, 2); cyc("R10");

    // R11: write to pending r4 keeps it pending; link to pending r1 likewise
    idle(); wr_en = 1; wr_idx = 4; wr_data = 16'h0D0D; ld_issue = 1; ld_idx = 1; cyc("R11");
    idle(); link_en = 1; link_addr = 16'h0E0E; cyc("R11");
    idle(); rd(4, 0); cyc("R11");
    idle(); rd(0, 1); cyc("R11");
    idle(); ld_done = 1; ld_done_idx = 4; ld_done_data = 16'h0F0F; cyc("R11");
    idle(); ld_done = 1; ld_done_idx = 1; ld_done_data = 16'h0101; cyc("R11");
    idle(); rd(4, 1); cyc("R11");

    // mixed traffic against the reference model
    for (int n = 0; n < 3000; n++) begin
      rd_a_en = 1'($urandom); rd_a_idx = 3'($urandom);
      rd_b_en = 1'($urandom); rd_b_idx = 3'($urandom);
      wr_en = 1'($urandom); wr_idx = 3'($urandom); wr_data = 16'($urandom);
      ld_issue = ($urandom % 4) == 0; ld_idx = 3'($urandom);
      ld_done = ($urandom % 3) == 0; ld_done_idx = 3'($urandom); ld_done_data = 16'($urandom);
      link_en = ($urandom % 8) == 0; link_addr = 16'($urandom);
      cyc("R5");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule